// File: doc/BRIEF.md
# Watchdog Timer with Magic-Word Start and Stop

This block is a watchdog down counter with a small word-addressed register port. Software loads a default count and a reset-pulse length. It then starts the countdown by writing a two-word arming sequence to the control register. Reading that control register returns the live count at any time. A second two-word sequence halts the countdown and reloads the counter from the default count. No other write to the control register moves the count.

The counter decrements only on cycles where `cnt_tick` is high. When the count reaches zero, a sticky watchdog flag is set at bit 3 of the status byte, and `wdog_rst_o` is asserted. The reset output stays high for the programmed number of reference ticks. A reference tick is a cycle with `ref_tick` high, and that input is meant to strobe at the 50 MHz reference rate. When the pulse ends, the watchdog returns to the stopped state with the counter reloaded. It does not start again until software arms it once more.

Register map, as `reg_addr` values:
- 0: default count.
- 1: control. A write feeds the sequence detector; a read returns the live count.
- 2: reset-pulse length, in reference ticks.
- 3: status byte. Bit 3 is the watchdog flag and bits 0 to 2 read as zero.

Top module: `wdog_unlock_top`

## Requirements
- R1: After synchronous reset, the watchdog is stopped. A control read returns the reset default count `DEF_CNT_RST`, `wdog_rst_o` is 0, and the status byte reads 0.
- R2: A control write of 0x0000FF00 followed by a control write of 0x000000FF starts the countdown. While running, the count drops by one on each cycle with `cnt_tick` high and holds on every other cycle.
- R3: A control write of 0x0000EE00 followed by a control write of 0x000000EE stops the countdown and loads the counter from the default-count register. While stopped, `cnt_tick` has no effect.
- R4: The second word of a sequence counts only if it is the very next control write. Any other control value in between cancels the partial sequence, and the second word alone does nothing. Writes to other addresses do not disturb a partial sequence.
- R5: A read at address 1 returns the live count, zero-extended.
- R6: When a running count reaches zero, status bit 3 (value 0x08) is set and `wdog_rst_o` rises on the same clock edge.
- R7: `wdog_rst_o` stays high for exactly the number of `ref_tick` cycles held in the pulse-length register. Cycles without `ref_tick` do not shorten it.
- R8: When the pulse ends, the watchdog is stopped and the count is reloaded from the default-count register.
- R9: Writing a word with bit 3 set to address 3 clears the watchdog flag. Writes with bit 3 clear leave the flag unchanged. A new expiry in the same cycle wins over the clear.
- R10: Start and stop sequences written while the reset pulse is active neither shorten the pulse nor change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Countdown enable strobe |
| ref_tick | input | 1 | Reference-rate strobe that times the reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| wdog_rst_o | output | 1 | Watchdog reset pulse |
| wdog_irq_o | output | 1 | Watchdog flag (status bit 3) |

## Verification
The sequence detector is exercised with:
- the proper arming pair;
- the proper halting pair;
- a first word followed by a stray control value and then the second word;
- a lone second word;
- a first word whose second word comes after an unrelated default-count write.

Together these separate "exactly the next control write" from "any later write" and from "the next write to any address".

The countdown is run both with idle cycles and with tick cycles between reads. This separates per-tick decrement from per-clock decrement.

The expiry path is driven with `ref_tick` held low for a while and then pulsed. This shows the pulse length is counted in reference ticks rather than clocks. A halting sequence written during the pulse shows it cannot cut the pulse short.

The flag is cleared with a zero word, with a word that has only the low bits set, and with bit 3. This separates write-one-to-clear from plain writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [DATA_W-1:0] ARM_W0  = 32'h0000_FF00;
    localparam logic [DATA_W-1:0] ARM_W1  = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] HALT_W0 = 32'h0000_EE00;
    localparam logic [DATA_W-1:0] HALT_W1 = 32'h0000_00EE;

    localparam int unsigned FLAG_BIT = 3;

    typedef enum logic [1:0] {
        A_DEFCNT = 2'd0,
        A_CTRL   = 2'd1,
        A_PULSE  = 2'd2,
        A_STAT   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ARM,
        PEND_HALT
    } pend_e;

    typedef enum logic [1:0] {
        WD_STOPPED,
        WD_RUNNING,
        WD_FIRING
    } wd_state_e;

    typedef struct packed {
        logic arm;
        logic halt;
    } seq_cmd_t;

    function automatic logic [DATA_W-1:0] stat_byte(input logic flag);
        logic [DATA_W-1:0] v;
        v = '0;
        v[FLAG_BIT] = flag;
        return v;
    endfunction

endpackage

// File: rtl/wdog_seq_det.sv
module wdog_seq_det
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output seq_cmd_t          cmd
);

    pend_e pend_q, pend_d;

    always_comb begin
        cmd.arm  = ctrl_wr && (pend_q == PEND_ARM)  && (wdata == ARM_W1);
        cmd.halt = ctrl_wr && (pend_q == PEND_HALT) && (wdata == HALT_W1);

        pend_d = pend_q;
        if (ctrl_wr) begin
            if (wdata == ARM_W0)       pend_d = PEND_ARM;
            else if (wdata == HALT_W0) pend_d = PEND_HALT;
            else                       pend_d = PEND_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= PEND_NONE;
        else     pend_q <= pend_d;
    end

    // R4
    no_lone_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata == ARM_W1 && pend_q != PEND_ARM) |-> !cmd.arm);

    // R4
    pend_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata != ARM_W0 && wdata != HALT_W0) |=> pend_q == PEND_NONE);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned DEF_CNT_RST = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_tick,
    input  seq_cmd_t         cmd,
    input  logic [CNT_W-1:0] def_cnt,
    input  logic             pulse_idle,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o,
    output wd_state_e        state_o
);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        unique case (st_q)
            WD_STOPPED: begin
                if (cmd.halt) cnt_d = def_cnt;
                else if (cmd.arm) st_d = WD_RUNNING;
            end
            WD_RUNNING: begin
                if (cmd.halt) begin
                    st_d  = WD_STOPPED;
                    cnt_d = def_cnt;
                end else if (cnt_tick) begin
                    if (cnt_q <= CNT_W'(1)) begin
                        cnt_d    = '0;
                        st_d     = WD_FIRING;
                        expire_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            WD_FIRING: begin
                if (pulse_idle) begin
                    st_d  = WD_STOPPED;
                    cnt_d = def_cnt;
                end
            end
            default: st_d = WD_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WD_STOPPED;
            cnt_q <= CNT_W'(DEF_CNT_RST);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign state_o = st_q;

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_RUNNING && !cnt_tick && !cmd.halt) |=> $stable(cnt_q));

    // R3
    halt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_RUNNING && cmd.halt) |=> (st_q == WD_STOPPED && cnt_q == $past(def_cnt)));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_STOPPED && !cmd.halt) |=> $stable(cnt_q));

    // R10
    fire_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_FIRING && !pulse_idle) |=> (st_q == WD_FIRING && cnt_q == '0));

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int unsigned PULSE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               ref_tick,
    input  logic [PULSE_W-1:0] pulse_len,
    output logic               rst_o,
    output logic               idle_o
);

    logic [PULSE_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)                                rem_q <= '0;
        else if (fire)                          rem_q <= pulse_len;
        else if (ref_tick && rem_q != '0)       rem_q <= rem_q - PULSE_W'(1);
    end

    assign rst_o  = (rem_q != '0);
    assign idle_o = (rem_q == '0);

    // R7
    rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick && !fire) |=> $stable(rem_q));

    // R7
    rem_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && !fire && rem_q != '0) |=> rem_q == $past(rem_q) - PULSE_W'(1));

endmodule

// File: rtl/wdog_unlock_top.sv
module wdog_unlock_top
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned PULSE_W     = 24,
    parameter int unsigned DEF_CNT_RST = 1000,
    parameter int unsigned PULSE_RST   = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_tick,
    input  logic              ref_tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdog_rst_o,
    output logic              wdog_irq_o
);

    reg_addr_e          addr;
    logic [CNT_W-1:0]   def_cnt_q;
    logic [PULSE_W-1:0] pulse_len_q;
    logic               flag_q;
    seq_cmd_t           cmd;
    logic [CNT_W-1:0]   live_cnt;
    logic               expire;
    logic               pulse_idle;
    wd_state_e          wd_state;
    logic               flag_clr;

    assign addr     = reg_addr_e'(reg_addr);
    assign flag_clr = reg_wr && (addr == A_STAT) && reg_wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            def_cnt_q   <= CNT_W'(DEF_CNT_RST);
            pulse_len_q <= PULSE_W'(PULSE_RST);
            flag_q      <= 1'b0;
        end else begin
            if (reg_wr && addr == A_DEFCNT) def_cnt_q   <= reg_wdata[CNT_W-1:0];
            if (reg_wr && addr == A_PULSE)  pulse_len_q <= reg_wdata[PULSE_W-1:0];
            if (expire)        flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    wdog_seq_det u_seq (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (reg_wr && addr == A_CTRL),
        .wdata   (reg_wdata),
        .cmd     (cmd)
    );

    wdog_counter #(
        .CNT_W       (CNT_W),
        .DEF_CNT_RST (DEF_CNT_RST)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cnt_tick   (cnt_tick),
        .cmd        (cmd),
        .def_cnt    (def_cnt_q),
        .pulse_idle (pulse_idle),
        .cnt_o      (live_cnt),
        .expire_o   (expire),
        .state_o    (wd_state)
    );

    wdog_rst_pulse #(
        .PULSE_W (PULSE_W)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .fire      (expire),
        .ref_tick  (ref_tick),
        .pulse_len (pulse_len_q),
        .rst_o     (wdog_rst_o),
        .idle_o    (pulse_idle)
    );

    always_comb begin
        unique case (addr)
            A_DEFCNT: reg_rdata = DATA_W'(def_cnt_q);
            A_CTRL:   reg_rdata = DATA_W'(live_cnt);
            A_PULSE:  reg_rdata = DATA_W'(pulse_len_q);
            default:  reg_rdata = stat_byte(flag_q);
        endcase
    end

    assign wdog_irq_o = flag_q;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> wdog_irq_o);

    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wdog_irq_o && !flag_clr) |=> wdog_irq_o);

    // R8
    back_to_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_state == WD_FIRING && pulse_idle) |=> (wd_state == WD_STOPPED && live_cnt == $past(def_cnt_q)));

endmodule

// File: tb/wdog_unlock_top_tb.sv
module wdog_unlock_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wdog_rst_o;
    logic        wdog_irq_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wdog_unlock_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .cnt_tick   (cnt_tick),
        .ref_tick   (ref_tick),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .wdog_rst_o (wdog_rst_o),
        .wdog_irq_o (wdog_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_tick = 1'b1;
            @(negedge clk); cnt_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd1, v); chk("R1 count", v, 32'd1000);
        chk("R1 rst_o", {31'd0, wdog_rst_o}, 32'd0);
        rd(2'd3, v); chk("R1 status", v, 32'd0);
        ticks(3);
        rd(2'd1, v); chk("R1 stopped", v, 32'd1000);
    endtask

    task automatic t_start_run();
        logic [31:0] v;
        wr(2'd0, 32'd20);
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h000000EE);
        rd(2'd1, v); chk("R3 reload", v, 32'd20);
        wr(2'd1, 32'h0000FF00); wr(2'd1, 32'h000000FF);
        idle(5);
        rd(2'd1, v); chk("R2 no tick hold", v, 32'd20);
        ticks(4);
        rd(2'd1, v); chk("R5 R2 live count", v, 32'd16);
        wr(2'd0, 32'd30);
        rd(2'd1, v); chk("R2 default write no effect", v, 32'd16);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h000000EE);
        rd(2'd1, v); chk("R3 stop reload", v, 32'd30);
        ticks(3);
        rd(2'd1, v); chk("R3 stopped hold", v, 32'd30);
    endtask

    task automatic t_broken_seq();
        logic [31:0] v;
        wr(2'd1, 32'h0000FF00); wr(2'd1, 32'h00001234); wr(2'd1, 32'h000000FF);
        ticks(2);
        rd(2'd1, v); chk("R4 interrupted", v, 32'd30);
        wr(2'd1, 32'h000000FF);
        ticks(2);
        rd(2'd1, v); chk("R4 lone second", v, 32'd30);
        wr(2'd1, 32'h0000FF00); wr(2'd0, 32'd30); wr(2'd1, 32'h000000FF);
        ticks(2);
        rd(2'd1, v); chk("R4 other address ok", v, 32'd28);
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h00000000); wr(2'd1, 32'h000000EE);
        ticks(1);
        rd(2'd1, v); chk("R4 halt interrupted", v, 32'd27);
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h000000EE);
        rd(2'd1, v); chk("R3 halted", v, 32'd30);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        wr(2'd0, 32'd3);
        wr(2'd2, 32'd4);
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h000000EE);
        wr(2'd1, 32'h0000FF00); wr(2'd1, 32'h000000FF);
        ticks(2);
        chk("R6 not yet", {31'd0, wdog_rst_o}, 32'd0);
        ticks(1);
        chk("R6 rst_o high", {31'd0, wdog_rst_o}, 32'd1);
        rd(2'd3, v); chk("R6 flag bit3", v, 32'h8);
        rd(2'd1, v); chk("R6 count zero", v, 32'd0);
        idle(6);
        chk("R7 held without ref", {31'd0, wdog_rst_o}, 32'd1);
        wr(2'd1, 32'h0000EE00); wr(2'd1, 32'h000000EE);
        wr(2'd1, 32'h0000FF00); wr(2'd1, 32'h000000FF);
        chk("R10 seq ignored", {31'd0, wdog_rst_o}, 32'd1);
        rd(2'd1, v); chk("R10 count", v, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
        chk("R7 after 3 ref", {31'd0, wdog_rst_o}, 32'd1);
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        chk("R7 after 4 ref", {31'd0, wdog_rst_o}, 32'd0);
        idle(2);
        rd(2'd1, v); chk("R8 reloaded", v, 32'd3);
        ticks(5);
        rd(2'd1, v); chk("R8 stays stopped", v, 32'd3);
        chk("R8 no new pulse", {31'd0, wdog_rst_o}, 32'd0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R9 zero write", v, 32'h8);
        wr(2'd3, 32'h7);
        rd(2'd3, v); chk("R9 low bits write", v, 32'h8);
        wr(2'd3, 32'h8);
        rd(2'd3, v); chk("R9 cleared", v, 32'h0);
        chk("R9 irq low", {31'd0, wdog_irq_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_run();
        t_stop();
        t_broken_seq();
        t_expire();
        t_w1c();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule